// File: doc/BRIEF.md
# Completion-Detecting Iterative Carry Adder

This block adds two unsigned W-bit operands and a carry-in over a data-dependent number of clock cycles. Rather than allowing a fixed worst-case time for carries to ripple, it tracks, for every bit position, whether the carry leaving that position is already known. It raises a completion flag in the first cycle in which every position's carry is known.

A position whose operand bits are both one always emits a carry. A position whose operand bits are both zero never emits one. Either of these settles on the first step. A position whose bits differ passes on whatever carry enters it, so it settles one step after its lower neighbour. The time to finish therefore follows the longest chain of such pass-through positions, which is short for typical data.

A one-cycle `start` pulse latches the operands while the block is idle. The sum, carry-out, completion flag and the number of resolution steps are registered. They stay unchanged until the next accepted start.

Top module: `carry_settle_adder`

## Requirements
- R1: After synchronous reset, `done`, `sum`, `cout` and `steps` are all zero.
- R2: A position counts as settled only once its outgoing carry is known to be 0 or known to be 1. `done` never asserts while any position is unsettled.
- R3: On the first step, a position with operand bits 11 settles to carry 1 and one with bits 00 settles to carry 0. A position with differing bits takes the carry status of the carry entering it; for bit 0 that is `cin`, which is known from the start. A settled position does not change while the addition is in progress.
- R4: When `done` is high, `{cout, sum}` equals `x_in + y_in + cin` as latched at the accepted start.
- R5: Step k is the k-th rising edge after the edge that accepts `start`. `done` and the results become valid at the edge of the step in which the last position settles. `steps` then holds that step number. This is the maximum over bit positions of s(i), where s(i) = 1 for bits 11 or 00, and s(i) = s(i-1) + 1 for differing bits, with s(-1) = 0.
- R6: Operands whose positions are all 11 or 00 finish with `steps` = 1. Operands whose positions all differ finish with `steps` = W, the maximum.
- R7: `start` is accepted while the block is idle, whether or not `done` is high. `done` falls at the accepting edge, and results stay held unchanged in the cycles between completion and the next accepted start.
- R8: `start` is ignored while an addition is in progress, including during the final resolution step. The operands in flight, the completion time and the results are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to latch operands and begin an addition |
| x_in | input | W | First operand |
| y_in | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Registered sum, valid while `done` is high |
| cout | output | 1 | Registered carry out of the top bit |
| done | output | 1 | High from completion until the next accepted start |
| steps | output | $clog2(W+1) | Number of resolution steps the last addition took |

## Verification
Two events can land in the same cycle: the final resolution step that raises `done`, and a new `start` request. The bench computes each operand set's resolution step count from R5. It then holds `start` high, with different operands, during exactly the last busy cycle. It judges the result by requiring `done` to rise on schedule with the original sum, and to stay high one cycle later, proving that no new addition began. The same request is also placed early in a long carry chain to check that the operands in flight are kept.

// File: rtl/cs_pkg.sv
package cs_pkg;
  // Carry status of one position: k1 = carry known one, k0 = carry known zero.
  typedef struct packed {
    logic k1;
    logic k0;
  } cst_t;

  localparam cst_t CST_OPEN = '{k1: 1'b0, k0: 1'b0};

  function automatic cst_t cst_from_bit(input logic b);
    cst_t r;
    r.k1 = b;
    r.k0 = ~b;
    return r;
  endfunction
endpackage

// File: rtl/cs_bit_cell.sv
module cs_bit_cell
  import cs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  input  logic xb,
  input  logic yb,
  input  cst_t lower,
  output cst_t st_q,
  output cst_t st_nxt
);
  logic gen_w;
  logic kill_w;

  assign gen_w  = xb & yb;
  assign kill_w = ~xb & ~yb;

  always_comb begin
    if (gen_w)       st_nxt = cst_from_bit(1'b1);
    else if (kill_w) st_nxt = cst_from_bit(1'b0);
    else             st_nxt = lower;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) st_q <= CST_OPEN;
    else if (step)    st_q <= st_nxt;
  end

  // R2: both flags set never appears
  p_status_legal_r2: assert property (@(posedge clk) disable iff (rst)
    !(st_q.k1 && st_q.k0));

  // R3: a settled position keeps its value while stepping
  p_settled_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !clear && (st_q.k1 || st_q.k0)) |=> (st_q == $past(st_q)));
endmodule

// File: rtl/cs_settle_detect.sv
module cs_settle_detect
  import cs_pkg::*;
#(
  parameter int W = 16
) (
  input  cst_t [W-1:0] st,
  output logic         all_set
);
  logic [W-1:0] settled;

  for (genvar i = 0; i < W; i++) begin : g_pos
    assign settled[i] = st[i].k1 | st[i].k0;
  end

  assign all_set = &settled;
endmodule

// File: rtl/carry_settle_adder.sv
module carry_settle_adder
  import cs_pkg::*;
#(
  parameter int W  = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  x_in,
  input  logic [W-1:0]  y_in,
  input  logic          cin,
  output logic [W-1:0]  sum,
  output logic          cout,
  output logic          done,
  output logic [CW-1:0] steps
);
  logic [W-1:0]  x_q, y_q;
  logic          cin_q;
  logic          busy_q;
  logic          done_q;
  logic [W-1:0]  sum_q;
  logic          cout_q;
  logic [CW-1:0] cnt_q;

  cst_t [W-1:0] st_q;
  cst_t [W-1:0] st_nxt;
  logic         all_set;
  logic         accept;
  logic         finish;
  logic [W-1:0] carry_vec;

  assign accept = start & ~busy_q;
  assign finish = busy_q & all_set;

  for (genvar i = 0; i < W; i++) begin : g_cell
    cst_t lower_w;
    if (i == 0) begin : g_lsb
      assign lower_w = cst_from_bit(cin_q);
    end else begin : g_upper
      assign lower_w = st_q[i-1];
    end
    cs_bit_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .clear  (accept),
      .step   (busy_q),
      .xb     (x_q[i]),
      .yb     (y_q[i]),
      .lower  (lower_w),
      .st_q   (st_q[i]),
      .st_nxt (st_nxt[i])
    );
    if (i == 0) begin : g_c0
      assign carry_vec[i] = cin_q;
    end else begin : g_ci
      assign carry_vec[i] = st_nxt[i-1].k1;
    end
  end

  cs_settle_detect #(.W(W)) u_detect (
    .st      (st_nxt),
    .all_set (all_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q    <= '0;
      y_q    <= '0;
      cin_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sum_q  <= '0;
      cout_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      x_q    <= x_in;
      y_q    <= y_in;
      cin_q  <= cin;
      busy_q <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + CW'(1);
      if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        sum_q  <= x_q ^ y_q ^ carry_vec;
        cout_q <= st_nxt[W-1].k1;
      end
    end
  end

  assign sum   = sum_q;
  assign cout  = cout_q;
  assign done  = done_q;
  assign steps = cnt_q;

  // R4: completed result matches arithmetic sum of latched operands
  p_sum_arith_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> ({cout_q, sum_q} == ({1'b0, x_q} + {1'b0, y_q} + {{W{1'b0}}, cin_q})));

  // R5: done and an addition in progress are exclusive
  p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !(done_q && busy_q));

  // R6: step count lies within 1..W once done
  p_count_range_r6: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (cnt_q >= CW'(1) && cnt_q <= CW'(W)));

  // R8: start during an addition leaves operands untouched
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> (x_q == $past(x_q) && y_q == $past(y_q) && cin_q == $past(cin_q)));
endmodule

// File: tb/carry_settle_adder_tb.sv
module carry_settle_adder_tb;
  localparam int W  = 16;
  localparam int CW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [W-1:0]  x_in, y_in;
  logic          cin;
  logic [W-1:0]  sum;
  logic          cout;
  logic          done;
  logic [CW-1:0] steps;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #5 clk = ~clk;

  carry_settle_adder #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .x_in(x_in), .y_in(y_in),
    .cin(cin), .sum(sum), .cout(cout), .done(done), .steps(steps)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL R5 watchdog: got %0d cycles expected below 150000", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int ref_steps(input logic [W-1:0] a, input logic [W-1:0] b);
    int prev = 0;
    int mx = 0;
    for (int i = 0; i < W; i++) begin
      int s;
      s = (a[i] ^ b[i]) ? prev + 1 : 1;
      if (s > mx) mx = s;
      prev = s;
    end
    return mx;
  endfunction

  function automatic logic [W:0] ref_sum(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  // mode 0: plain; 1: extra start early; 2: extra start in the final step
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                        input int mode, input bit hold_chk);
    int exp_n;
    int k;
    bit seen;
    logic [W:0] exp_s;
    exp_n = ref_steps(a, b);
    exp_s = ref_sum(a, b, c);
    x_in = a; y_in = b; cin = c; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    // R7: done falls at the accepting edge
    chk(done == 1'b0, "R7 done cleared on accept", done, 0);
    k = 0;
    seen = 1'b0;
    while (!seen && k < W + 4) begin
      if (mode == 1 && k == 1) begin
        start = 1'b1; x_in = ~a; y_in = a; cin = ~c;
      end
      if (mode == 2 && k == exp_n - 1) begin
        start = 1'b1; x_in = a ^ 16'h5a5a; y_in = ~b; cin = ~c;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      k++;
      if (done) seen = 1'b1;
    end
    // R2 R5: completion neither early nor late
    chk(k == exp_n, "R2 R5 completion step", k, exp_n);
    chk(int'(steps) == exp_n, "R5 step count", steps, exp_n);
    chk({cout, sum} == exp_s, "R4 sum and carry", {cout, sum}, exp_s);
    if (mode != 0) begin
      @(posedge clk);
      @(negedge clk);
      chk(done == 1'b1, "R8 start in flight ignored, done held", done, 1);
      chk({cout, sum} == exp_s, "R8 result unchanged", {cout, sum}, exp_s);
    end
    if (hold_chk) begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(done == 1'b1 && {cout, sum} == exp_s, "R7 results held while idle", {cout, sum}, exp_s);
    end
  endtask

  initial begin
    logic [W-1:0] a, b;
    void'($urandom(32'd20240611));
    rst = 1'b1; start = 1'b0; x_in = '0; y_in = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    chk(done == 1'b0 && sum == '0 && cout == 1'b0 && steps == '0, "R1 reset state",
        {done, cout, sum, steps}, 0);

    // R6 / R3: generate and kill only -> one step
    run_op(16'h0000, 16'h0000, 1'b0, 0, 1'b1);
    chk(steps == CW'(1), "R6 all kill single step", steps, 1);
    run_op(16'hffff, 16'hffff, 1'b1, 0, 1'b0);
    chk(steps == CW'(1), "R6 all generate single step", steps, 1);
    run_op(16'hff00, 16'hff00, 1'b1, 0, 1'b0);
    chk(steps == CW'(1), "R3 mixed generate kill single step", steps, 1);
    // R6: full propagate from cin -> W steps
    run_op(16'hffff, 16'h0000, 1'b1, 0, 1'b1);
    chk(steps == CW'(W), "R6 full chain cin=1", steps, W);
    run_op(16'haaaa, 16'h5555, 1'b0, 0, 1'b0);
    chk(steps == CW'(W), "R6 full chain cin=0", steps, W);
    // R3: chain fed by a generate at bit 0
    run_op(16'h7fff, 16'h0001, 1'b0, 0, 1'b0);
    chk(steps == CW'(15), "R3 chain after generate", steps, 15);
    // R8: start during the run and during the last step
    run_op(16'h0fff, 16'h0001, 1'b0, 1, 1'b0);
    run_op(16'h00ff, 16'h0100, 1'b1, 2, 1'b0);
    run_op(16'h1234, 16'h1234, 1'b0, 2, 1'b1);

    for (int n = 0; n < 300; n++) begin
      a = W'($urandom);
      b = W'($urandom);
      if (n % 4 == 1) b = ~a ^ W'(1 << ($urandom % W));
      run_op(a, b, 1'($urandom), (n % 10 == 3) ? 1 : ((n % 10 == 7) ? 2 : 0), n % 25 == 0);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule